// File: doc/BRIEF.md
# Supervisory Reset Generator with Chip-Enable Gating

This block produces a pair of complementary processor reset outputs from two causes: a digitized flag that says the supply has fallen below its threshold, and an active-low manual-reset pin. Reset goes active as soon as a cause is present. It stays active for a programmable hold-off period that begins only after every cause has cleared. A new supply dip during the hold-off starts the period again from zero.

The block also gates an active-low memory chip-enable line, so that the memory cannot be written while the system is in reset. When the gate is open, the chip-enable output follows the input through logic only, with no register in the path. Once reset becomes active, the gate stays open for a short programmable delay and then closes. While closed, it drives the output to the inactive-high level. The gate opens again in the same cycle that reset releases. After power-on, the gate therefore stays closed for the whole first timeout.

The manual-reset pin is asynchronous and passes through a synchronizer before use. Every delay is a parameter given in clock cycles. Analog sensing, thresholds and drive strengths belong to other blocks.

Top module: `sup_reset_gate`

## Requirements
- R1: In any cycle where `supply_low_i` is 1, `rst_n_o` is 0 in that same cycle, with no clock edge needed.
- R2: `mr_n_i` passes through SYNC_STAGES flip-flops (default 2). When `mr_n_i` goes low, reset becomes active after the SYNC_STAGES-th rising edge that samples it low. It stays active for as long as the synchronized pin stays low.
- R3: Count the rising edges at which no cause is present, starting at the first such edge. Reset stays active through the first RST_TIMEOUT_CYC-1 of these edges and releases right after edge number RST_TIMEOUT_CYC.
- R4: If a cause returns before the hold-off completes, the count restarts from zero. Reset then releases only after RST_TIMEOUT_CYC further quiet edges.
- R5: `rst_o` is always the exact inverse of `rst_n_o`.
- R6: After reset becomes active with the gate open, `ce_n_o` keeps following `ce_n_i` through the first CE_DIS_DELAY_CYC-1 rising edges. The gate closes right after edge number CE_DIS_DELAY_CYC.
- R7: While the gate is closed, `ce_n_o` is 1 whatever value `ce_n_i` takes.
- R8: The gate opens in the same cycle that `rst_n_o` returns to 1, and never while reset is active. After power-on reset, the gate stays closed until the first hold-off ends.
- R9: While reset is inactive, `ce_n_o` equals `ce_n_i` within the same cycle, with no clock edge.
- R10: While `rst_n` is low, reset is active. After `rst_n` is released, with no cause present, reset releases after exactly RST_TIMEOUT_CYC rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| supply_low_i | input | 1 | Digitized supply-below-threshold flag, active high |
| mr_n_i | input | 1 | Asynchronous manual reset, active low |
| ce_n_i | input | 1 | Chip-enable from address decode, active low |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| ce_n_o | output | 1 | Gated chip-enable to memory, active low |

## Verification
The bench counts quiet edges after each cause clears and expects release on exactly the edge the hold-off length gives. An off-by-one counter would show up as reset releasing one cycle early or late. A supply dip placed in the middle of the hold-off must stretch reset by a full period. A counter that only paused, or that ignored the dip, would release too soon.

The bench checks the gate edge by edge while it closes. It expects `ce_n_o` to follow `ce_n_i` for the delay and then stick high. A design that closed at once, or never closed, would fail this check. It also expects the gate to open on the release cycle, not one cycle later, and checks that it stays closed through the timeout after power-on. Manual reset is checked against the two-stage synchronizer latency.

// File: rtl/sup_pkg.sv
package sup_pkg;

   // counter width able to hold values 0..n
   function automatic int cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   typedef enum logic {
      GATE_OPEN = 1'b0,
      GATE_SHUT = 1'b1
   } gate_e;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sup_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q[0] <= RESET_VAL;
      else        chain_q[0] <= d_i;
   end

   genvar gi;
   generate
      for (gi = 1; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[gi] <= RESET_VAL;
            else        chain_q[gi] <= chain_q[gi-1];
         end

         // R2: each stage carries the previous one forward by one edge
         assert_sync_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> chain_q[gi] == $past(chain_q[gi-1]));
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
   parameter int TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cause_i,
   output logic active_o
);
   import sup_pkg::*;

   localparam int            CW   = cnt_width(TIMEOUT);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

   generate
      if (TIMEOUT < 1) begin : g_bad_timeout
         $error("sup_hold_timer: TIMEOUT must be at least 1");
      end
   endgenerate

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (cause_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign active_o = !rst_n || cause_i || busy_q;

   // R3: release only after the counter has reached its final value
   assert_release_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !active_o && $past(active_o)) |-> ($past(cnt_q) == LAST));

   // R4: any cause restarts the hold-off from zero
   assert_restart_on_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cause_i)) |-> (busy_q && cnt_q == '0));

endmodule

// File: rtl/sup_ce_gate.sv
module sup_ce_gate #(
   parameter int DELAY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_reset_i,
   input  logic ce_n_i,
   output logic ce_n_o
);
   import sup_pkg::*;

   localparam int            DW   = cnt_width(DELAY);
   localparam logic [DW-1:0] LAST = DW'(DELAY - 1);

   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("sup_ce_gate: DELAY must be at least 1");
      end
   endgenerate

   gate_e         gate_q;
   logic [DW-1:0] dcnt_q;
   logic          blocked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q <= GATE_SHUT;
         dcnt_q <= '0;
      end else if (!in_reset_i) begin
         gate_q <= GATE_OPEN;
         dcnt_q <= '0;
      end else if (gate_q == GATE_OPEN) begin
         if (dcnt_q == LAST) gate_q <= GATE_SHUT;
         else                dcnt_q <= dcnt_q + 1'b1;
      end
   end

   assign blocked = (gate_q == GATE_SHUT) && in_reset_i;
   assign ce_n_o  = blocked ? 1'b1 : ce_n_i;

   // R6: the gate shuts only at the end of the delay, inside a reset
   assert_shut_after_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && gate_q == GATE_SHUT && $past(gate_q) == GATE_OPEN)
         |-> ($past(dcnt_q) == LAST && $past(in_reset_i)));

endmodule

// File: rtl/sup_reset_gate.sv
module sup_reset_gate #(
   parameter int RST_TIMEOUT_CYC  = 50_000_000,
   parameter int CE_DIS_DELAY_CYC = 7000,
   parameter int SYNC_STAGES      = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low_i,
   input  logic mr_n_i,
   input  logic ce_n_i,
   output logic rst_n_o,
   output logic rst_o,
   output logic ce_n_o
);

   logic mr_n_s;
   logic cause;
   logic in_reset;

   sup_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
   ) i_mr_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (mr_n_i),
      .q_o  (mr_n_s)
   );

   assign cause = supply_low_i || !mr_n_s;

   sup_hold_timer #(
      .TIMEOUT(RST_TIMEOUT_CYC)
   ) i_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .cause_i (cause),
      .active_o(in_reset)
   );

   sup_ce_gate #(
      .DELAY(CE_DIS_DELAY_CYC)
   ) i_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_reset_i(in_reset),
      .ce_n_i    (ce_n_i),
      .ce_n_o    (ce_n_o)
   );

   assign rst_n_o = !in_reset;
   assign rst_o   = in_reset;

   // R1: a supply dip shows at the reset pin without waiting for an edge
   assert_dip_resets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      supply_low_i |-> !rst_n_o);

   // R5: complementary outputs
   assert_outputs_inverse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o != rst_n_o);

   // R8: outside reset the gate passes the enable through
   assert_open_outside_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n_o |-> (ce_n_o == ce_n_i));

endmodule

// File: tb/test_sup_reset_gate.sv
`timescale 1ns/100ps
module test_sup_reset_gate;

   localparam int T = 6;
   localparam int D = 3;

   logic clk = 1'b0;
   logic rst_n, supply_low_i, mr_n_i, ce_n_i;
   logic rst_n_o, rst_o, ce_n_o;
   int   checks = 0;
   int   errors = 0;
   bit   done   = 0;

   always #2 clk = ~clk;

   sup_reset_gate #(
      .RST_TIMEOUT_CYC (T),
      .CE_DIS_DELAY_CYC(D),
      .SYNC_STAGES     (2)
   ) i_sup_reset_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_low_i(supply_low_i),
      .mr_n_i      (mr_n_i),
      .ce_n_i      (ce_n_i),
      .rst_n_o     (rst_n_o),
      .rst_o       (rst_o),
      .ce_n_o      (ce_n_o)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   // checks both reset pins against the expected active state
   task automatic check_rst(input string tag, input logic exp_active);
      check({tag, " rst_n_o"}, rst_n_o, !exp_active);
      check({"R5 ", tag, " rst_o"}, rst_o, exp_active);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // run the hold-off after the last cause cleared; release after edge n
   task automatic run_holdoff(input string tag, input int n);
      for (int i = 1; i <= n; i++) begin
         tick();
         #0.5;
         check_rst(tag, i < n);
         if (i < n) check({"R7 ", tag, " gate shut"}, ce_n_o, 1'b1);
         else       check({"R8 ", tag, " gate reopens"}, ce_n_o, ce_n_i);
      end
   endtask

   task automatic t_power_on();
      rst_n = 1'b0; supply_low_i = 1'b0; mr_n_i = 1'b1; ce_n_i = 1'b0;
      repeat (3) tick();
      #0.5;
      check_rst("R10 in power-on reset", 1'b1);
      check("R7 gate shut in power-on reset", ce_n_o, 1'b1);
      rst_n = 1'b1;
      run_holdoff("R10 R8 power-up", T);
   endtask

   task automatic t_pass_through();
      tick();
      ce_n_i = 1'b1; #0.5;
      check("R9 pass high", ce_n_o, 1'b1);
      ce_n_i = 1'b0; #0.5;
      check("R9 pass low", ce_n_o, 1'b0);
      check_rst("R9 idle", 1'b0);
   endtask

   task automatic t_supply_dip();
      tick();
      supply_low_i = 1'b1; ce_n_i = 1'b0; #0.5;
      check_rst("R1 immediate", 1'b1);
      check("R6 gate open at assert", ce_n_o, 1'b0);
      for (int i = 1; i <= D; i++) begin
         tick();
         #0.5;
         check("R6 gate delay", ce_n_o, (i >= D));
      end
      ce_n_i = 1'b1; #0.5;
      ce_n_i = 1'b0; #0.5;
      check("R7 ce ignored while shut", ce_n_o, 1'b1);
      repeat (2) tick();
      supply_low_i = 1'b0;
      run_holdoff("R3 supply release", T);
   endtask

   task automatic t_restart();
      tick();
      supply_low_i = 1'b1;
      repeat (D + 1) tick();
      supply_low_i = 1'b0;
      for (int i = 1; i <= 3; i++) begin
         tick();
         #0.5;
         check_rst("R4 before dip", 1'b1);
      end
      supply_low_i = 1'b1;
      tick();
      supply_low_i = 1'b0; #0.5;
      check("R7 gate stays shut over dip", ce_n_o, 1'b1);
      run_holdoff("R4 restarted", T);
   endtask

   task automatic t_manual();
      tick();
      mr_n_i = 1'b0;
      tick(); #0.5;
      check_rst("R2 after one edge", 1'b0);
      tick(); #0.5;
      check_rst("R2 after two edges", 1'b1);
      repeat (D + 2) tick();
      #0.5;
      check("R7 gate shut in manual reset", ce_n_o, 1'b1);
      check_rst("R2 held while low", 1'b1);
      mr_n_i = 1'b1;
      run_holdoff("R2 R3 manual release", T + 2);
   endtask

   initial begin
      t_power_on();
      t_pass_through();
      t_supply_dip();
      t_pass_through();
      t_restart();
      t_manual();
      t_pass_through();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule